// File: doc/BRIEF.md
# Power-Good Delay Sequencer

This block decides when the open-drain power-good line of a switching regulator is pulled low. It runs on the system clock, but all of its qualification timing is measured in switching cycles, which arrive as a one-clock strobe `cyc_tick`. At each strobe it samples a soft-start-complete flag and the undervoltage and overvoltage comparator flags. These analog functions sit outside the block and are modelled here as digital inputs.

Power-good is reported only after soft-start has finished and the feedback has stayed inside the regulation window for 128 switching cycles in a row. Once reported, an out-of-window condition has to persist for three consecutive switching cycles before the line is pulled low again. This keeps the pull-down latency inside a 1-to-6-cycle bound and rejects short glitches. Removing the enable or losing the power-on-reset condition drives the pull-down at once, through a combinational path that bypasses both qualification counters. The registered state is also cleared, so every restart needs a complete 128-cycle qualification.

Top module: `pgd_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the not-good state. After that edge `pg_good` reads 0 and `pg_pull` reads 1.
- R2: With `en` and `por_ok` high, a switching cycle qualifies when `ss_done` is 1 and both `uv_trip` and `ov_trip` are 0. `pg_good` rises and `pg_pull` falls at the clock edge that samples the 128th consecutive qualifying `cyc_tick`, and not at any earlier edge.
- R3: The feedback counts as out of window when `uv_trip` is 1, when `ov_trip` is 1, or when both are 1.
- R4: A non-qualifying tick seen before the count of 128 completes discards the run. Release then needs 128 new consecutive qualifying ticks.
- R5: While `ss_done` is 0, no release happens, however long the feedback stays in window.
- R6: While good, `pg_pull` rises at the edge that samples the third consecutive out-of-window tick. This latency lies within the 1-to-6-cycle bound.
- R7: While good, an out-of-window run of one or two ticks followed by an in-window tick leaves `pg_good` at 1 and `pg_pull` at 0.
- R8: When `en` is 0, `pg_pull` is 1 in the same cycle with no clock edge needed, and `pg_good` is 0 after the next clock edge.
- R9: When `por_ok` is 0, `pg_pull` is 1 in the same cycle with no clock edge needed, and `pg_good` is 0 after the next clock edge.
- R10: Input values on clock cycles without `cyc_tick` neither advance nor reset either qualification count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_tick | input | 1 | One-clock strobe per switching cycle |
| ss_done | input | 1 | Soft-start ramp has completed |
| uv_trip | input | 1 | Feedback below the lower window limit |
| ov_trip | input | 1 | Feedback above the upper window limit |
| en | input | 1 | Regulator enable; 0 forces the pull-down |
| por_ok | input | 1 | Supply above power-on-reset level; 0 forces the pull-down |
| pg_pull | output | 1 | Pull-down enable for the open-drain power-good transistor |
| pg_good | output | 1 | Registered qualified power-good state |

## Verification
The bench times release exactly, one tick short of 128 and at 128, so a counter that is off by one releases a cycle early or late. It breaks a qualifying run at tick 127 to catch a design that merely pauses its count instead of restarting it. Fault runs of one, two and three ticks separate a filter that is too shallow, which drops on a glitch, from one that is too deep, which misses the latency bound. It checks `pg_pull` just after `en` or `por_ok` falls, before any clock edge, which exposes a bypass that was wrongly registered. Garbage on non-tick cycles catches a design that samples its inputs on every clock.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

    localparam int PGD_REL_TICKS = 128;
    localparam int PGD_FLT_TICKS = 3;

    typedef struct packed {
        logic ss_done;
        logic uv;
        logic ov;
    } pgd_sense_t;

    function automatic int cnt_bits(input int limit);
        return (limit <= 2) ? 1 : $clog2(limit);
    endfunction

    function automatic logic out_of_window(input pgd_sense_t s);
        return s.uv | s.ov;
    endfunction

    function automatic logic release_ok(input pgd_sense_t s);
        return s.ss_done & ~out_of_window(s);
    endfunction

endpackage

// File: rtl/pgd_window.sv
module pgd_window
    import pgd_pkg::*;
(
    input  pgd_sense_t sense,
    output logic       qual,
    output logic       bad
);
    always_comb begin
        qual = release_ok(sense);
        bad  = out_of_window(sense);
    end
endmodule

// File: rtl/pgd_run_cnt.sv
module pgd_run_cnt
    import pgd_pkg::*;
#(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic hit,
    output logic done
);
    localparam int W = cnt_bits(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign done = tick & hit & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            if (!hit || done) cnt <= '0;
            else              cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pgd_seq.sv
module pgd_seq
    import pgd_pkg::*;
#(
    parameter int REL_TICKS = PGD_REL_TICKS,
    parameter int FLT_TICKS = PGD_FLT_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_tick,
    input  logic ss_done,
    input  logic uv_trip,
    input  logic ov_trip,
    input  logic en,
    input  logic por_ok,
    output logic pg_pull,
    output logic pg_good
);
    pgd_sense_t sense;
    logic act, qual, bad, rel_done, flt_done, good_q;

    assign sense = '{ss_done: ss_done, uv: uv_trip, ov: ov_trip};
    assign act   = en & por_ok;

    pgd_window u_win (
        .sense (sense),
        .qual  (qual),
        .bad   (bad)
    );

    pgd_run_cnt #(.LIMIT(REL_TICKS)) u_rel (
        .clk  (clk),
        .rst  (rst),
        .clr  (~act | good_q),
        .tick (cyc_tick),
        .hit  (qual),
        .done (rel_done)
    );

    pgd_run_cnt #(.LIMIT(FLT_TICKS)) u_flt (
        .clk  (clk),
        .rst  (rst),
        .clr  (~act | ~good_q),
        .tick (cyc_tick),
        .hit  (bad),
        .done (flt_done)
    );

    always_ff @(posedge clk) begin
        if (rst || !act)              good_q <= 1'b0;
        else if (!good_q && rel_done) good_q <= 1'b1;
        else if (good_q && flt_done)  good_q <= 1'b0;
    end

    assign pg_good = good_q;
    assign pg_pull = ~good_q | ~act;
endmodule

// File: rtl/pgd_seq_chk.sv
module pgd_seq_chk
    import pgd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic cyc_tick,
    input logic ss_done,
    input logic uv_trip,
    input logic ov_trip,
    input logic en,
    input logic por_ok,
    input logic pg_pull,
    input logic pg_good
);
    logic [8:0] run;
    logic q_tick;
    assign q_tick = cyc_tick && ss_done && !uv_trip && !ov_trip;

    always_ff @(posedge clk) begin
        if (rst || !(en && por_ok) || pg_good) run <= '0;
        else if (cyc_tick && !q_tick)         run <= '0;
        else if (q_tick && run != 9'h1FF)     run <= run + 1'b1;
    end

    a_r8_disable_pulls: assert property (@(posedge clk) disable iff (rst)
        !en |-> pg_pull);

    a_r9_por_pulls: assert property (@(posedge clk) disable iff (rst)
        !por_ok |-> pg_pull);

    a_r2_release_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_good) |-> $past(q_tick && en && por_ok));

    a_r4_full_streak: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_good) |-> run == 9'(PGD_REL_TICKS));

    a_r6_drop_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(pg_good) |-> $past(!en || !por_ok || (cyc_tick && (uv_trip || ov_trip))));

    a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (!cyc_tick && en && por_ok) |=> $stable(pg_good));

    a_r2_good_releases: assert property (@(posedge clk) disable iff (rst)
        (pg_good && en && por_ok) |-> !pg_pull);
endmodule

bind pgd_seq pgd_seq_chk u_chk (.*);

// File: tb/pgd_seq_test.sv
module pgd_seq_test;
    logic clk = 1'b0;
    logic rst, cyc_tick, ss_done, uv_trip, ov_trip, en, por_ok;
    logic pg_pull, pg_good;

    int n_run = 0, n_fail = 0;
    int m_rel = 0, m_flt = 0;
    bit m_good = 1'b0;
    bit finished = 1'b0;
    int unsigned seed_init;

    always #4 clk = ~clk;

    pgd_seq uut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ss_done(ss_done),
        .uv_trip(uv_trip), .ov_trip(ov_trip), .en(en), .por_ok(por_ok),
        .pg_pull(pg_pull), .pg_good(pg_good)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_clear();
        m_good = 1'b0; m_rel = 0; m_flt = 0;
    endfunction

    function automatic void model_tick(input logic s, input logic u, input logic o);
        if (!m_good) begin
            m_flt = 0;
            if (s && !u && !o) begin
                if (m_rel == 127) begin m_good = 1'b1; m_rel = 0; end
                else m_rel++;
            end else m_rel = 0;
        end else begin
            m_rel = 0;
            if (u || o) begin
                if (m_flt == 2) begin m_good = 1'b0; m_flt = 0; end
                else m_flt++;
            end else m_flt = 0;
        end
    endfunction

    // one switching cycle: tick clock then three idle clocks carrying junk
    task automatic do_tick(input logic s, input logic u, input logic o, input string req);
        @(negedge clk);
        ss_done = s; uv_trip = u; ov_trip = o; cyc_tick = 1'b1;
        @(negedge clk);
        cyc_tick = 1'b0;
        model_tick(s, u, o);
        chk(req, pg_good, m_good);
        chk(req, pg_pull, ~m_good);
        for (int i = 0; i < 3; i++) begin
            ss_done = 1'($urandom); uv_trip = 1'($urandom); ov_trip = 1'($urandom);
            @(negedge clk);
        end
        chk("R10", pg_good, m_good);
    endtask

    task automatic qualify(input string req);
        for (int i = 0; i < 128; i++) do_tick(1'b1, 1'b0, 1'b0, req);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        seed_init = $urandom(32'd20250);
        rst = 1'b1; cyc_tick = 1'b0; ss_done = 1'b0; uv_trip = 1'b0;
        ov_trip = 1'b0; en = 1'b1; por_ok = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", pg_good, 1'b0);
        chk("R1", pg_pull, 1'b1);
        rst = 1'b0;

        // R5: soft-start pending blocks release
        for (int i = 0; i < 150; i++) do_tick(1'b0, 1'b0, 1'b0, "R5");
        // R2: exact release at 128
        for (int i = 0; i < 127; i++) do_tick(1'b1, 1'b0, 1'b0, "R2");
        chk("R2", pg_pull, 1'b1);
        do_tick(1'b1, 1'b0, 1'b0, "R2");
        chk("R2", pg_pull, 1'b0);

        // R7: glitches of one and two ticks, uv and ov
        do_tick(1'b1, 1'b1, 1'b0, "R7"); do_tick(1'b1, 1'b0, 1'b0, "R7");
        do_tick(1'b1, 1'b0, 1'b1, "R7"); do_tick(1'b1, 1'b1, 1'b1, "R7");
        do_tick(1'b1, 1'b0, 1'b0, "R7");
        chk("R7", pg_good, 1'b1);
        // R6 / R3: third consecutive out-of-window tick drops
        do_tick(1'b1, 1'b0, 1'b1, "R6"); do_tick(1'b1, 1'b0, 1'b1, "R6");
        chk("R6", pg_pull, 1'b0);
        do_tick(1'b1, 1'b1, 1'b1, "R3");
        chk("R6", pg_pull, 1'b1);

        // R4: break at 127 restarts
        for (int i = 0; i < 127; i++) do_tick(1'b1, 1'b0, 1'b0, "R4");
        do_tick(1'b1, 1'b1, 1'b0, "R4");
        for (int i = 0; i < 127; i++) do_tick(1'b1, 1'b0, 1'b0, "R4");
        chk("R4", pg_pull, 1'b1);
        do_tick(1'b1, 1'b0, 1'b0, "R4");
        chk("R4", pg_good, 1'b1);

        // R8: enable removed pulls at once
        @(negedge clk); en = 1'b0; #1;
        chk("R8", pg_pull, 1'b1);
        @(negedge clk);
        chk("R8", pg_good, 1'b0);
        en = 1'b1; model_clear();
        for (int i = 0; i < 127; i++) do_tick(1'b1, 1'b0, 1'b0, "R8");
        chk("R8", pg_pull, 1'b1);
        do_tick(1'b1, 1'b0, 1'b0, "R8");

        // R9: power-on-reset loss pulls at once
        @(negedge clk); por_ok = 1'b0; #1;
        chk("R9", pg_pull, 1'b1);
        @(negedge clk);
        chk("R9", pg_good, 1'b0);
        por_ok = 1'b1; model_clear();

        // random segments of mixed fault density
        for (int seg = 0; seg < 40; seg++) begin
            int mode = int'($urandom % 4);
            if (mode == 3 && ($urandom % 3) == 0) begin
                @(negedge clk);
                if ($urandom % 2) en = 1'b0; else por_ok = 1'b0;
                #1 chk("R8", pg_pull, 1'b1);
                @(negedge clk);
                en = 1'b1; por_ok = 1'b1; model_clear();
            end
            for (int t = 0; t < 40; t++) begin
                logic s, u, o;
                s = (mode == 2) ? 1'(($urandom % 8) != 0) : 1'b1;
                u = (mode == 0) ? 1'b0 : (mode == 1) ? 1'(($urandom % 16) == 0)
                                                     : 1'(($urandom % 2) == 0);
                o = (mode == 0) ? 1'b0 : 1'(($urandom % 16) == 0);
                do_tick(s, u, o, "R2");
            end
            if (mode == 0) qualify("R2");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule